// File: doc/BRIEF.md
# Register-Width-Relative Sign Extender

This unit takes a register operand of XLEN bits and sign-extends a low field of it back to the full XLEN width. The field size is a fraction of the register width rather than a fixed bit count: an eighth, a quarter or a half of XLEN, picked by a 2-bit operation code. At XLEN=64 the three sizes come out as the familiar 8-, 16- and 32-bit extends. At smaller widths they shrink with the register: at XLEN=8 the fields are 1, 2 and 4 bits.

An execution pipeline presents an operand, an operation code and a valid strobe in one cycle. The extended result and its own valid strobe appear one clock later. A small output state machine has three states. ST_IDLE means no result. ST_RESULT means a valid extended value. ST_FAULT means an unusable operation code was seen. The state machine moves on every clock edge as follows:
- It goes to ST_IDLE when there is no valid input.
- It goes to ST_RESULT on a valid input with codes 00, 01 or 10.
- It goes to ST_FAULT on a valid input with code 11.
- Synchronous reset forces ST_IDLE.

Top module: `xlen_sext_unit`

## Requirements
- R1: Operation code 00 extends the low XLEN/8 bits of the operand (8 bits at XLEN=64, 1 bit at XLEN=8).
- R2: Operation code 01 extends the low XLEN/4 bits of the operand (16 bits at XLEN=64, 2 bits at XLEN=8).
- R3: Operation code 10 extends the low XLEN/2 bits of the operand (32 bits at XLEN=64, 4 bits at XLEN=8).
- R4: The top bit of the selected field is copied into every result bit above the field, and the field itself appears unchanged in the low bits of the result.
- R5: Operand bits above the selected field have no influence on the result.
- R6: Operation code 11 with a valid input gives out_valid=1, out_illegal=1 and out_data=0 in the next cycle.
- R7: out_valid is high in the cycle after a cycle in which in_valid was high, and low in the cycle after a cycle in which it was low.
- R8: While rst_n is low at a clock edge, the next outputs are out_valid=0, out_illegal=0 and out_data=0, whatever the inputs are.
- R9: Whenever out_valid is low, out_data is zero and out_illegal is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand and operation code are present this cycle |
| in_op | input | 2 | Field size: 00 eighth, 01 quarter, 10 half, 11 illegal |
| in_data | input | XLEN | Register operand |
| out_valid | output | 1 | Result registered from the previous cycle is valid |
| out_illegal | output | 1 | The previous valid input carried code 11 |
| out_data | output | XLEN | Sign-extended result, zero when idle or illegal |

## Verification
The properties assume that in_op and in_data hold known values in every cycle in which in_valid is high. They assume nothing about those inputs while in_valid is low. They also assume that XLEN is one of 8, 16, 32 or 64, so that every field width is a whole number of bits. The stimulus meets these assumptions by changing every input only on the falling clock edge. It gives every input a defined value from time zero, and it runs two instances, at XLEN=64 and at XLEN=8. Operands are chosen so that the bits above each field are the opposite of the field's sign, which exposes any leak of upper bits into the result.

// File: rtl/xsx_pkg.sv
package xsx_pkg;

    typedef enum logic [1:0] {
        OP_EIGHTH  = 2'b00,
        OP_QUARTER = 2'b01,
        OP_HALF    = 2'b10,
        OP_BAD     = 2'b11
    } xsx_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_RESULT = 2'b01,
        ST_FAULT  = 2'b10
    } xsx_state_e;

    localparam int NUM_SIZES = 3;

endpackage

// File: rtl/xsx_field_ext.sv
module xsx_field_ext #(
    parameter int XLEN = 64,
    parameter int FW   = 8
) (
    input  logic [FW-1:0]   fld,
    output logic [XLEN-1:0] ext
);
    localparam int FILL = XLEN - FW;

    // Copy the field's top bit into every position above the field.
    assign ext = {{FILL{fld[FW-1]}}, fld};

endmodule

// File: rtl/xsx_out_stage.sv
module xsx_out_stage
    import xsx_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [1:0]      in_op,
    input  logic [XLEN-1:0] ext_eighth,
    input  logic [XLEN-1:0] ext_quarter,
    input  logic [XLEN-1:0] ext_half,
    output logic            out_valid,
    output logic            out_illegal,
    output logic [XLEN-1:0] out_data
);
    xsx_state_e      state_q, state_d;
    logic [XLEN-1:0] data_q, data_d;

    always_comb begin
        state_d = ST_IDLE;
        data_d  = '0;
        if (in_valid) begin
            unique case (xsx_op_e'(in_op))
                OP_EIGHTH:  begin state_d = ST_RESULT; data_d = ext_eighth;  end
                OP_QUARTER: begin state_d = ST_RESULT; data_d = ext_quarter; end
                OP_HALF:    begin state_d = ST_RESULT; data_d = ext_half;    end
                OP_BAD:     begin state_d = ST_FAULT;  data_d = '0;          end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            data_q  <= data_d;
        end
    end

    always_comb begin
        out_valid   = 1'b0;
        out_illegal = 1'b0;
        out_data    = '0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_RESULT: begin out_valid = 1'b1; out_data = data_q; end
            ST_FAULT:  begin out_valid = 1'b1; out_illegal = 1'b1; end
            default:   ;
        endcase
    end

    p_valid_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_bad_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 2'b11) |=> (out_illegal && out_data == '0));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_data == '0 && !out_illegal));

    p_reset_clears_r8: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_illegal && out_data == '0));

endmodule

// File: rtl/xlen_sext_unit.sv
module xlen_sext_unit
    import xsx_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [1:0]      in_op,
    input  logic [XLEN-1:0] in_data,
    output logic            out_valid,
    output logic            out_illegal,
    output logic [XLEN-1:0] out_data
);
    localparam int FW_EIGHTH  = XLEN / 8;
    localparam int FW_QUARTER = XLEN / 4;
    localparam int FW_HALF    = XLEN / 2;

    logic [XLEN-1:0] ext_vec [NUM_SIZES];

    // Size index g selects a field of XLEN >> (3-g) bits.
    generate
        for (genvar g = 0; g < NUM_SIZES; g++) begin : g_ext
            localparam int FW = XLEN >> (3 - g);
            xsx_field_ext #(.XLEN(XLEN), .FW(FW)) u_ext (
                .fld (in_data[FW-1:0]),
                .ext (ext_vec[g])
            );
        end
    endgenerate

    xsx_out_stage #(.XLEN(XLEN)) u_stage (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_op       (in_op),
        .ext_eighth  (ext_vec[0]),
        .ext_quarter (ext_vec[1]),
        .ext_half    (ext_vec[2]),
        .out_valid   (out_valid),
        .out_illegal (out_illegal),
        .out_data    (out_data)
    );

    // R1 with R4: the low field passes through, and the upper bits are all equal to the field's top bit.
    p_eighth_field_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 2'b00) |=>
        (out_data[FW_EIGHTH-1:0] == $past(in_data[FW_EIGHTH-1:0]) &&
         $countones(out_data[XLEN-1:FW_EIGHTH-1]) ==
             ($past(in_data[FW_EIGHTH-1]) ? (XLEN - FW_EIGHTH + 1) : 0)));

    p_quarter_field_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 2'b01) |=>
        (out_data[FW_QUARTER-1:0] == $past(in_data[FW_QUARTER-1:0]) &&
         $countones(out_data[XLEN-1:FW_QUARTER-1]) ==
             ($past(in_data[FW_QUARTER-1]) ? (XLEN - FW_QUARTER + 1) : 0)));

    p_half_field_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 2'b10) |=>
        (out_data[FW_HALF-1:0] == $past(in_data[FW_HALF-1:0]) &&
         $countones(out_data[XLEN-1:FW_HALF-1]) ==
             ($past(in_data[FW_HALF-1]) ? (XLEN - FW_HALF + 1) : 0)));

endmodule

// File: tb/xlen_sext_unit_tb_top.sv
module xlen_sext_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;

    // Each entry holds: op [130:129], operand [128:65], illegal [64], expected [63:0].
    localparam logic [130:0] VEC [NVEC] = '{
        {2'b00, 64'hFFFF_FFFF_FFFF_FF7F, 1'b0, 64'h0000_0000_0000_007F}, // R1 R5 positive byte, upper ones
        {2'b00, 64'h0000_0000_0000_0080, 1'b0, 64'hFFFF_FFFF_FFFF_FF80}, // R1 R4 negative byte
        {2'b01, 64'h0000_0000_0000_8001, 1'b0, 64'hFFFF_FFFF_FFFF_8001}, // R2 R4 negative quarter
        {2'b01, 64'hABCD_0000_1234_7FFF, 1'b0, 64'h0000_0000_0000_7FFF}, // R2 R5 positive quarter
        {2'b10, 64'h0000_0000_8000_0000, 1'b0, 64'hFFFF_FFFF_8000_0000}, // R3 R4 negative half
        {2'b10, 64'hFFFF_FFFF_7FFF_FFFF, 1'b0, 64'h0000_0000_7FFF_FFFF}, // R3 R5 positive half
        {2'b11, 64'h0000_0000_0000_1234, 1'b1, 64'h0000_0000_0000_0000}, // R6 illegal code
        {2'b00, 64'h0000_0000_0000_0000, 1'b0, 64'h0000_0000_0000_0000}  // R1 zero
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_op = 2'b00;
    logic [63:0] in_data = '0;
    logic [7:0]  in_data8 = '0;
    logic        out_valid, out_illegal;
    logic [63:0] out_data;
    logic        out_valid8, out_illegal8;
    logic [7:0]  out_data8;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xlen_sext_unit #(.XLEN(64)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_data(in_data), .out_valid(out_valid), .out_illegal(out_illegal),
        .out_data(out_data)
    );

    xlen_sext_unit #(.XLEN(8)) dut8_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_data(in_data8), .out_valid(out_valid8), .out_illegal(out_illegal8),
        .out_data(out_data8)
    );

    task automatic chk(input string req, input logic [65:0] act, input logic [65:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected value at XLEN=8, worked out from the field widths 1, 2 and 4.
    function automatic logic [7:0] ref8(input logic [7:0] d, input logic [1:0] op);
        int fw;
        logic [7:0] mask;
        fw = 8 >> (3 - int'(op));
        mask = 8'((16'd1 << fw) - 16'd1);
        return d[fw-1] ? ((d & mask) | ~mask) : (d & mask);
    endfunction

    task automatic run8(input string req, input logic [1:0] op, input logic [7:0] d);
        in_valid = 1'b1; in_op = op; in_data8 = d;
        @(negedge clk);
        chk(req, {1'b0, out_valid8, 56'd0, out_data8}, {1'b0, 1'b1, 56'd0, ref8(d, op)});
    endtask

    initial begin
        // R8: reset is held for two edges while a valid input is presented.
        in_valid = 1'b1; in_op = 2'b00; in_data = 64'h80; in_data8 = 8'h01;
        @(negedge clk); @(negedge clk);
        chk("R8", {out_valid, out_illegal, out_data}, 66'd0);
        chk("R8", {out_valid8, out_illegal8, 56'd0, out_data8}, 66'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            string req;
            in_valid = 1'b1;
            in_op    = VEC[i][130:129];
            in_data  = VEC[i][128:65];
            case (in_op)
                2'b00:   req = "R1 R4 R5";
                2'b01:   req = "R2 R4 R5";
                2'b10:   req = "R3 R4 R5";
                default: req = "R6";
            endcase
            @(negedge clk);
            chk(req, {out_valid, out_illegal, out_data}, {1'b1, VEC[i][64:0]});
        end

        // R7 and R9: no valid input leads to an idle, zeroed output.
        in_valid = 1'b0; in_op = 2'b01; in_data = 64'hFFFF_FFFF_FFFF_FFFF;
        @(negedge clk);
        chk("R7 R9", {out_valid, out_illegal, out_data}, 66'd0);

        // R6 followed by a legal code: the illegal flag does not stay set.
        in_valid = 1'b1; in_op = 2'b11; in_data = 64'hFFFF;
        @(negedge clk);
        chk("R6", {out_valid, out_illegal, out_data}, {2'b11, 64'd0});
        in_op = 2'b10; in_data = 64'h0000_0001_0000_0001;
        @(negedge clk);
        chk("R3 R5", {out_valid, out_illegal, out_data}, {2'b10, 64'h1});

        // Field widths scale at XLEN=8.
        run8("R1 R4", 2'b00, 8'h01);
        run8("R1 R5", 2'b00, 8'hFE);
        run8("R2 R4", 2'b01, 8'h02);
        run8("R2 R5", 2'b01, 8'hFD);
        run8("R3 R4", 2'b10, 8'h08);
        run8("R3 R5", 2'b10, 8'hF7);

        // R8: reset in the middle of a stream of valid inputs.
        in_valid = 1'b1; in_op = 2'b00; in_data = 64'hFF; rst_n = 1'b0;
        @(negedge clk);
        chk("R8", {out_valid, out_illegal, out_data}, 66'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 R7", {out_valid, out_illegal, out_data}, {2'b10, 64'hFFFF_FFFF_FFFF_FFFF});

        in_valid = 1'b0;
        @(negedge clk);
        chk("R9", {out_valid, out_illegal, out_data}, 66'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule